// File: doc/BRIEF.md
# Gate-Aware Synchronous FIFO

This block is a small first-in first-out buffer that sits inside a gated clock domain. The domain clock is modelled as two signals: a free-running oscillator (`clk`) and an enable that says whether the domain is active. The enable is built from a parent gate and a chain of condition inputs. Each level of the chain is the level below it ANDed with one more condition. The last level is the gate of the FIFO.

The FIFO offers four operations: enqueue, dequeue, clear and a look at the oldest element. Each operation that changes state has a ready output. That ready depends on both the fill level and the composed gate, so no action is accepted while the domain is off. The look port does not change state and is not guarded. It keeps the readiness it had when the gate closed, because nothing inside can move while the gate is low. State changes only on oscillator edges where the composed gate is high.

Top module: `gated_fifo`

## Requirements
- R1: `gate_lvl[0]` equals `parent_gate`, and `gate_lvl[k+1]` equals `gate_lvl[k] & cond[k]`. `domain_on` equals `gate_lvl[NCOND]`, the AND of the parent gate and every condition.
- R2: Whenever any gate level is high, every lower level is also high.
- R3: `enq_ready` is `domain_on` with `count < DEPTH`. `deq_ready` is `domain_on` with `count > 0`. `clr_ready` is `domain_on`.
- R4: While `domain_on` is low, requests on enqueue, dequeue and clear have no effect: `count`, `first_valid` and `first_data` stay as they were at the next edge.
- R5: `first_valid` is high exactly when `count > 0`, whatever the gate. While it is high, `first_data` is the oldest stored element.
- R6: A clear with `clr_en` high and `domain_on` high empties the FIFO at that edge. It takes precedence over any enqueue or dequeue in the same cycle, which is then dropped.
- R7: Elements leave in the order they entered. `count` never exceeds `DEPTH`, and an enqueue request while full is ignored.
- R8: An enqueue and a dequeue that fire in the same cycle leave `count` unchanged, and both elements keep their order.
- R9: After reset, `count` is 0 and `first_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running domain oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| parent_gate | input | 1 | Gate of the parent domain |
| cond | input | NCOND | Condition inputs, one per derived gate level |
| gate_lvl | output | NCOND+1 | Gate at every nesting level |
| domain_on | output | 1 | Composed gate of the FIFO domain |
| enq_valid | input | 1 | Enqueue request |
| enq_data | input | WIDTH | Element to enqueue |
| enq_ready | output | 1 | Enqueue can fire |
| deq_en | input | 1 | Dequeue request |
| deq_ready | output | 1 | Dequeue can fire |
| clr_en | input | 1 | Clear request |
| clr_ready | output | 1 | Clear can fire |
| first_valid | output | 1 | Oldest element present |
| first_data | output | WIDTH | Oldest element |
| count | output | $clog2(DEPTH+1) | Number of stored elements |

## Verification
The hardest situation to reach is the gate closing while the FIFO holds data and all three action requests are pending. Only that case shows that the look port keeps its readiness while every action is refused. The bench drives this on purpose: it fills the buffer part-way, drops a single condition, asserts enqueue, dequeue and clear together, and then reopens the gate. After that, a long random phase toggles the parent gate and each condition independently on top of random requests. This reaches gate closures at empty, partly full and full levels, and clears that collide with enqueues.

// File: rtl/gated_fifo.sv
module gated_fifo #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 4,
  parameter int NCOND = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         parent_gate,
  input  logic [NCOND-1:0]             cond,
  output logic [NCOND:0]               gate_lvl,
  output logic                         domain_on,
  input  logic                         enq_valid,
  input  logic [WIDTH-1:0]             enq_data,
  output logic                         enq_ready,
  input  logic                         deq_en,
  output logic                         deq_ready,
  input  logic                         clr_en,
  output logic                         clr_ready,
  output logic                         first_valid,
  output logic [WIDTH-1:0]             first_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic             clr_go, enq_go, deq_go;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    gate_lvl[0] = parent_gate;
    for (int k = 0; k < NCOND; k++)
      gate_lvl[k+1] = gate_lvl[k] & cond[k];
  end

  assign domain_on   = gate_lvl[NCOND];
  assign enq_ready   = domain_on && (count != CW'(DEPTH));
  assign deq_ready   = domain_on && (count != '0);
  assign clr_ready   = domain_on;
  assign first_valid = (count != '0);
  assign first_data  = mem[rd_ptr];

  assign clr_go = clr_en & clr_ready;
  assign enq_go = enq_valid & enq_ready & ~clr_go;
  assign deq_go = deq_en & deq_ready & ~clr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (domain_on) begin
      if (clr_go) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        count  <= '0;
      end else begin
        if (enq_go) wr_ptr <= bump(wr_ptr);
        if (deq_go) rd_ptr <= bump(rd_ptr);
        count <= count + CW'(enq_go) - CW'(deq_go);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (domain_on && enq_go) mem[wr_ptr] <= enq_data;
  end
endmodule

// File: rtl/gated_fifo_chk.sv
module gated_fifo_chk #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 4,
  parameter int NCOND = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCOND:0]             gate_lvl,
  input logic                       domain_on,
  input logic                       enq_valid,
  input logic                       enq_ready,
  input logic                       deq_en,
  input logic                       deq_ready,
  input logic                       clr_en,
  input logic                       clr_ready,
  input logic                       first_valid,
  input logic [WIDTH-1:0]           first_data,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  a_r3_enq_guard: assert property (@(posedge clk) disable iff (!rst_n)
    enq_ready |-> (domain_on && int'(count) < DEPTH));

  a_r3_deq_guard: assert property (@(posedge clk) disable iff (!rst_n)
    deq_ready |-> (domain_on && first_valid));

  a_r4_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ready |=> ($stable(count) && $stable(first_data)));

  a_r5_look_held: assert property (@(posedge clk) disable iff (!rst_n)
    !domain_on |=> $stable(first_valid));

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_ready) |=> (count == '0));

  a_r8_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready && deq_en && deq_ready && !clr_en) |=> $stable(count));

  a_r2_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    domain_on |-> gate_lvl[0]);
endmodule

bind gated_fifo gated_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NCOND(NCOND)) u_chk (.*);

// File: tb/test_gated_fifo.sv
`timescale 1ns/1ps
module test_gated_fifo;
  localparam int WIDTH = 3;
  localparam int DEPTH = 4;
  localparam int NCOND = 2;

  logic clk = 0, rst_n = 0, parent_gate = 0;
  logic [NCOND-1:0] cond = '0;
  logic [NCOND:0] gate_lvl;
  logic domain_on, enq_valid = 0, enq_ready, deq_en = 0, deq_ready;
  logic clr_en = 0, clr_ready, first_valid;
  logic [WIDTH-1:0] enq_data = '0, first_data;
  logic [$clog2(DEPTH+1)-1:0] count;

  int checks = 0, fails = 0;
  int q[$];
  bit done = 0;

  always #5 clk = ~clk;

  gated_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NCOND(NCOND)) i_gated_fifo (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive inputs after a negedge, compare at +2ns, then advance model at posedge
  task automatic step(input bit pg, input logic [NCOND-1:0] cd, input bit ev,
                      input int ed, input bit de, input bit ce);
    int lvl, on, er, dr;
    parent_gate = pg; cond = cd; enq_valid = ev; enq_data = WIDTH'(ed);
    deq_en = de; clr_en = ce;
    #2;
    lvl = pg;
    for (int k = 0; k < NCOND; k++) lvl = lvl | ((((lvl >> k) & 1) & cd[k]) << (k + 1));
    on = (lvl >> NCOND) & 1;
    er = on && q.size() < DEPTH;
    dr = on && q.size() > 0;
    chk(gate_lvl == (NCOND+1)'(lvl), "R1 gate levels", int'(gate_lvl), lvl);
    chk(domain_on == on[0], "R1 composed gate", domain_on, on);
    for (int k = 1; k <= NCOND; k++)
      if (gate_lvl[k]) chk(gate_lvl[k-1], "R2 ancestor active", gate_lvl[k-1], 1);
    chk(enq_ready == er[0], "R3 enq_ready", enq_ready, er);
    chk(deq_ready == dr[0], "R3 deq_ready", deq_ready, dr);
    chk(clr_ready == on[0], "R3 clr_ready", clr_ready, on);
    chk(int'(count) == q.size(), "R7 count", count, q.size());
    chk(first_valid == (q.size() > 0), "R5 first_valid", first_valid, q.size() > 0);
    if (q.size() > 0) chk(int'(first_data) == q[0], "R5 first_data", first_data, q[0]);
    if (on) begin
      if (ce) q.delete();
      else begin
        if (de && dr) void'(q.pop_front());
        if (ev && er) q.push_back(ed % (1 << WIDTH));
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9 reset state
    chk(count == 0, "R9 reset count", count, 0);
    chk(first_valid == 0, "R9 reset first_valid", first_valid, 0);
    rst_n = 1;
    @(negedge clk);
    // R7 fill past full, overflow ignored
    for (int i = 0; i < DEPTH + 2; i++) step(1, '1, 1, i + 1, 0, 0);
    // R7 order on drain
    step(1, '1, 0, 0, 1, 0);
    step(1, '1, 0, 0, 1, 0);
    // R8 simultaneous enq/deq
    step(1, '1, 1, 6, 1, 0);
    step(1, '1, 1, 7, 1, 0);
    // R4/R5 gate off via one condition with all requests pending
    for (int i = 0; i < 5; i++) step(1, 2'b01, 1, 5, 1, 1);
    step(0, '1, 1, 5, 1, 1);
    step(1, '1, 0, 0, 0, 0);
    // R6 clear beats enqueue
    step(1, '1, 1, 3, 1, 1);
    step(1, '1, 0, 0, 0, 0);
    // gate off while empty
    step(1, 2'b10, 1, 2, 0, 0);
    step(1, '1, 0, 0, 0, 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [NCOND-1:0] cd;
      for (int k = 0; k < NCOND; k++) cd[k] = ($urandom % 5) != 0;
      step(($urandom % 6) != 0, cd, $urandom % 2, $urandom % 8,
           ($urandom % 3) == 0, ($urandom % 25) == 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule